// File: doc/BRIEF.md
# Trap-Return State Update Unit

This unit carries out the architectural side effects of the two trap-return instructions of a RISC-V-style core: the return from supervisor level and the return from machine level. A request arrives with a return-type select, a snapshot of the current privilege level and virtualization flag, the status and hypervisor-status fields that the return touches, both exception-PC registers, and the core's configuration flags. These flags cover compressed-instruction support, user mode, the hypervisor extension, physical memory protection (PMP), whether any PMP rule is configured, and whether the core follows privilege-spec version 1.12 or later.

One clock after the request the unit presents a result. If one of its permission or alignment checks fails, the result is an exception code and all state fields are passed through unchanged. If every check passes, the result is the new status fields, the new privilege level, the new virtualization flag and the return PC. The unit does not exchange the hypervisor register banks itself. It raises a flag that tells the surrounding core to do so.

Privilege levels are encoded as user = 0, supervisor = 1 and machine = 3. The supervisor previous-privilege field is one bit, where 1 means supervisor.

Top module: `trap_ret_unit`

## Requirements
- R1: A supervisor return issued at user level, or a machine return issued below machine level, yields exception code 2 (illegal instruction).
- R2: When compressed instructions are not supported and bits [1:0] of the selected return PC are not both zero, the result is exception code 0 (misaligned target). With compressed support, bit 1 set is accepted.
- R3: A supervisor return yields code 2 when the trap-supervisor-return control is set and the level is below machine. It yields code 22 (virtual instruction) when virtualization is on and the hypervisor's virtual trap-supervisor-return control is set.
- R4: A successful supervisor return copies the supervisor previous-enable into the supervisor enable, sets the previous-enable to 1, clears the previous-privilege bit, takes the new privilege from the old previous-privilege bit, and returns the supervisor exception PC.
- R5: With the spec-1.12 flag set, a supervisor return always clears the modify-privilege bit, and a machine return clears it only when the old machine previous-privilege is not machine. Without the flag, the bit is kept.
- R6: A supervisor return with the hypervisor extension present and virtualization off takes the new virtualization flag from the supervisor previous-virtualization bit, then clears that bit, and raises the bank-swap flag when the bit was 1. In every other case the virtualization flag and that bit are kept.
- R7: A successful machine return copies the machine previous-enable into the machine enable and sets the previous-enable to 1. It sets the machine previous-privilege to user when user mode exists and to machine otherwise, clears the machine previous-virtualization bit, takes the new privilege from the old previous-privilege field, and returns the machine exception PC.
- R8: A machine return sets the new virtualization flag to (old machine previous-virtualization AND old previous-privilege not machine) and raises the bank-swap flag when that value is 1, only when the hypervisor extension is present. Otherwise the flag is kept and no swap is signalled.
- R9: A machine return yields code 1 (instruction access fault) when PMP is supported, no PMP rule is configured, and the old machine previous-privilege is not machine.
- R10: Checks are ordered as follows, and the first failing one sets the code: privilege level (R1), then alignment (R2), then the return-type-specific checks (R3 in its listed order, or R9).
- R11: On an exception, every status output, the privilege and the virtualization flag equal their request-time inputs, and the bank-swap flag is 0.
- R12: Reset clears the done and exception outputs. The done output is 1 exactly in the cycle after a cycle with a request, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Return request this cycle |
| req_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cur_virt | input | 1 | Current virtualization flag |
| in_ie_s | input | 1 | Supervisor interrupt enable |
| in_pie_s | input | 1 | Supervisor previous enable |
| in_pp_s | input | 1 | Supervisor previous privilege (1 = S) |
| in_ie_m | input | 1 | Machine interrupt enable |
| in_pie_m | input | 1 | Machine previous enable |
| in_pp_m | input | 2 | Machine previous privilege |
| in_pv_m | input | 1 | Machine previous virtualization |
| in_mprv | input | 1 | Modify-privilege bit |
| in_trap_sret | input | 1 | Trap supervisor return control |
| in_pv_s | input | 1 | Hypervisor supervisor previous virtualization |
| in_vtrap_sret | input | 1 | Hypervisor virtual trap supervisor return control |
| sepc_i | input | XLEN | Supervisor exception PC |
| mepc_i | input | XLEN | Machine exception PC |
| cfg_c | input | 1 | Compressed instructions supported |
| cfg_u | input | 1 | User mode supported |
| cfg_h | input | 1 | Hypervisor extension present |
| cfg_pmp | input | 1 | PMP supported |
| cfg_v112 | input | 1 | Privilege spec 1.12 or later |
| cfg_pmp_rules | input | 1 | At least one PMP rule configured |
| done_o | output | 1 | Result valid |
| exc_o | output | 1 | Result is an exception |
| exc_code_o | output | 5 | Exception code (0, 1, 2, 22) |
| out_ie_s | output | 1 | New supervisor enable |
| out_pie_s | output | 1 | New supervisor previous enable |
| out_pp_s | output | 1 | New supervisor previous privilege |
| out_ie_m | output | 1 | New machine enable |
| out_pie_m | output | 1 | New machine previous enable |
| out_pp_m | output | 2 | New machine previous privilege |
| out_pv_m | output | 1 | New machine previous virtualization |
| out_mprv | output | 1 | New modify-privilege bit |
| out_pv_s | output | 1 | New supervisor previous virtualization |
| new_priv_o | output | 2 | New privilege |
| new_virt_o | output | 1 | New virtualization flag |
| ret_pc_o | output | XLEN | Return PC |
| bank_swap_o | output | 1 | Hypervisor register banks must be swapped |

## Verification
Every result passes through exactly one register, so it is due on the first rising edge after the edge at which the request was seen. The done pulse falls one edge later. Each scenario task raises the request on a falling edge, lowers it on the next falling edge, and reads all outputs at that second falling edge, midway between the capturing edge and the following one. One task then leaves the request low for a further period and confirms that done has fallen, which shows that a result is never stretched or repeated.

// File: rtl/trap_ret_pkg.sv
package trap_ret_pkg;

    localparam int EXC_W = 5;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [EXC_W-1:0] EXC_MISALIGN = 5'd0;
    localparam logic [EXC_W-1:0] EXC_ACCESS   = 5'd1;
    localparam logic [EXC_W-1:0] EXC_ILLEGAL  = 5'd2;
    localparam logic [EXC_W-1:0] EXC_VIRTUAL  = 5'd22;

    typedef struct packed {
        logic       ie_s;
        logic       pie_s;
        logic       pp_s;
        logic       ie_m;
        logic       pie_m;
        logic [1:0] pp_m;
        logic       pv_m;
        logic       mprv;
        logic       pv_s;
    } ret_status_t;

endpackage

// File: rtl/tru_excp_check.sv
module tru_excp_check
    import trap_ret_pkg::*;
(
    input  logic             is_mret,
    input  logic [1:0]       cur_priv,
    input  logic             cur_virt,
    input  logic             trap_sret,
    input  logic             vtrap_sret,
    input  logic [1:0]       epc_lo,
    input  logic [1:0]       prev_pp_m,
    input  logic             has_c,
    input  logic             has_pmp,
    input  logic             pmp_rules,
    output logic             fault,
    output logic [EXC_W-1:0] code
);
    logic priv_low;
    logic misaligned;

    always_comb begin
        priv_low   = is_mret ? (cur_priv != PRIV_M) : (cur_priv == PRIV_U);
        misaligned = !has_c && (epc_lo != 2'b00);
        fault      = 1'b1;
        code       = EXC_ILLEGAL;
        if (priv_low) begin
            code = EXC_ILLEGAL;
        end else if (misaligned) begin
            code = EXC_MISALIGN;
        end else if (!is_mret && trap_sret && (cur_priv != PRIV_M)) begin
            code = EXC_ILLEGAL;
        end else if (!is_mret && cur_virt && vtrap_sret) begin
            code = EXC_VIRTUAL;
        end else if (is_mret && has_pmp && !pmp_rules && (prev_pp_m != PRIV_M)) begin
            code = EXC_ACCESS;
        end else begin
            fault = 1'b0;
        end
    end
endmodule

// File: rtl/tru_state_update.sv
module tru_state_update
    import trap_ret_pkg::*;
(
    input  logic        is_mret,
    input  logic        cur_virt,
    input  ret_status_t st_in,
    input  logic        has_u,
    input  logic        has_h,
    input  logic        v112,
    output ret_status_t st_out,
    output logic [1:0]  priv_out,
    output logic        virt_out,
    output logic        swap_out
);
    logic from_m;
    logic m_virt;

    always_comb begin
        st_out   = st_in;
        virt_out = cur_virt;
        swap_out = 1'b0;
        from_m   = (st_in.pp_m == PRIV_M);
        m_virt   = st_in.pv_m && !from_m;
        if (is_mret) begin
            st_out.ie_m  = st_in.pie_m;
            st_out.pie_m = 1'b1;
            st_out.pp_m  = has_u ? PRIV_U : PRIV_M;
            st_out.pv_m  = 1'b0;
            if (v112 && !from_m) begin
                st_out.mprv = 1'b0;
            end
            priv_out = st_in.pp_m;
            if (has_h) begin
                virt_out = m_virt;
                swap_out = m_virt;
            end
        end else begin
            st_out.ie_s  = st_in.pie_s;
            st_out.pie_s = 1'b1;
            st_out.pp_s  = 1'b0;
            if (v112) begin
                st_out.mprv = 1'b0;
            end
            priv_out = {1'b0, st_in.pp_s};
            if (has_h && !cur_virt) begin
                virt_out    = st_in.pv_s;
                st_out.pv_s = 1'b0;
                swap_out    = st_in.pv_s;
            end
        end
    end
endmodule

// File: rtl/trap_ret_unit.sv
module trap_ret_unit
    import trap_ret_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_mret,
    input  logic [1:0]       cur_priv,
    input  logic             cur_virt,
    input  logic             in_ie_s,
    input  logic             in_pie_s,
    input  logic             in_pp_s,
    input  logic             in_ie_m,
    input  logic             in_pie_m,
    input  logic [1:0]       in_pp_m,
    input  logic             in_pv_m,
    input  logic             in_mprv,
    input  logic             in_trap_sret,
    input  logic             in_pv_s,
    input  logic             in_vtrap_sret,
    input  logic [XLEN-1:0]  sepc_i,
    input  logic [XLEN-1:0]  mepc_i,
    input  logic             cfg_c,
    input  logic             cfg_u,
    input  logic             cfg_h,
    input  logic             cfg_pmp,
    input  logic             cfg_v112,
    input  logic             cfg_pmp_rules,
    output logic             done_o,
    output logic             exc_o,
    output logic [EXC_W-1:0] exc_code_o,
    output logic             out_ie_s,
    output logic             out_pie_s,
    output logic             out_pp_s,
    output logic             out_ie_m,
    output logic             out_pie_m,
    output logic [1:0]       out_pp_m,
    output logic             out_pv_m,
    output logic             out_mprv,
    output logic             out_pv_s,
    output logic [1:0]       new_priv_o,
    output logic             new_virt_o,
    output logic [XLEN-1:0]  ret_pc_o,
    output logic             bank_swap_o
);
    localparam int PC_LSB_W = 2;

    typedef struct packed {
        logic             done;
        logic             exc;
        logic [EXC_W-1:0] code;
        ret_status_t      st;
        logic [1:0]       priv;
        logic             virt;
        logic [XLEN-1:0]  pc;
        logic             swap;
    } result_t;

    result_t     res_d, res_q;
    ret_status_t st_in, st_upd;
    logic [XLEN-1:0] epc_sel;
    logic        fault;
    logic [EXC_W-1:0] fault_code;
    logic [1:0]  upd_priv;
    logic        upd_virt;
    logic        upd_swap;

    assign st_in = '{ie_s: in_ie_s, pie_s: in_pie_s, pp_s: in_pp_s,
                     ie_m: in_ie_m, pie_m: in_pie_m, pp_m: in_pp_m,
                     pv_m: in_pv_m, mprv: in_mprv, pv_s: in_pv_s};
    assign epc_sel = req_mret ? mepc_i : sepc_i;

    tru_excp_check u_check (
        .is_mret    (req_mret),
        .cur_priv   (cur_priv),
        .cur_virt   (cur_virt),
        .trap_sret  (in_trap_sret),
        .vtrap_sret (in_vtrap_sret),
        .epc_lo     (epc_sel[PC_LSB_W-1:0]),
        .prev_pp_m  (in_pp_m),
        .has_c      (cfg_c),
        .has_pmp    (cfg_pmp),
        .pmp_rules  (cfg_pmp_rules),
        .fault      (fault),
        .code       (fault_code)
    );

    tru_state_update u_update (
        .is_mret  (req_mret),
        .cur_virt (cur_virt),
        .st_in    (st_in),
        .has_u    (cfg_u),
        .has_h    (cfg_h),
        .v112     (cfg_v112),
        .st_out   (st_upd),
        .priv_out (upd_priv),
        .virt_out (upd_virt),
        .swap_out (upd_swap)
    );

    always_comb begin
        res_d      = res_q;
        res_d.done = 1'b0;
        if (req_valid) begin
            res_d.done = 1'b1;
            res_d.pc   = epc_sel;
            if (fault) begin
                res_d.exc  = 1'b1;
                res_d.code = fault_code;
                res_d.st   = st_in;
                res_d.priv = cur_priv;
                res_d.virt = cur_virt;
                res_d.swap = 1'b0;
            end else begin
                res_d.exc  = 1'b0;
                res_d.code = '0;
                res_d.st   = st_upd;
                res_d.priv = upd_priv;
                res_d.virt = upd_virt;
                res_d.swap = upd_swap;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign done_o      = res_q.done;
    assign exc_o       = res_q.exc;
    assign exc_code_o  = res_q.code;
    assign out_ie_s    = res_q.st.ie_s;
    assign out_pie_s   = res_q.st.pie_s;
    assign out_pp_s    = res_q.st.pp_s;
    assign out_ie_m    = res_q.st.ie_m;
    assign out_pie_m   = res_q.st.pie_m;
    assign out_pp_m    = res_q.st.pp_m;
    assign out_pv_m    = res_q.st.pv_m;
    assign out_mprv    = res_q.st.mprv;
    assign out_pv_s    = res_q.st.pv_s;
    assign new_priv_o  = res_q.priv;
    assign new_virt_o  = res_q.virt;
    assign ret_pc_o    = res_q.pc;
    assign bank_swap_o = res_q.swap;

    AST_USER_SRET_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_mret && cur_priv == PRIV_U) |-> (exc_o && exc_code_o == EXC_ILLEGAL)); // R1
    AST_SRET_PIE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !exc_o && !$past(req_mret)) |-> out_pie_s); // R4
    AST_MRET_PV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !exc_o && $past(req_mret)) |-> !out_pv_m); // R7
    AST_EXC_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && exc_o) |-> (!bank_swap_o && new_priv_o == $past(cur_priv)
                               && new_virt_o == $past(cur_virt))); // R11
    AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done_o); // R12
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(req_valid)); // R12
endmodule

// File: tb/trap_ret_unit_bench.sv
module trap_ret_unit_bench;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, req_mret;
    logic [1:0] cur_priv;
    logic cur_virt, in_ie_s, in_pie_s, in_pp_s, in_ie_m, in_pie_m;
    logic [1:0] in_pp_m;
    logic in_pv_m, in_mprv, in_trap_sret, in_pv_s, in_vtrap_sret;
    logic [XLEN-1:0] sepc_i, mepc_i;
    logic cfg_c, cfg_u, cfg_h, cfg_pmp, cfg_v112, cfg_pmp_rules;
    logic done_o, exc_o;
    logic [4:0] exc_code_o;
    logic out_ie_s, out_pie_s, out_pp_s, out_ie_m, out_pie_m;
    logic [1:0] out_pp_m;
    logic out_pv_m, out_mprv, out_pv_s;
    logic [1:0] new_priv_o;
    logic new_virt_o;
    logic [XLEN-1:0] ret_pc_o;
    logic bank_swap_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    trap_ret_unit #(.XLEN(XLEN)) u_trap_ret_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mret(req_mret),
        .cur_priv(cur_priv), .cur_virt(cur_virt), .in_ie_s(in_ie_s),
        .in_pie_s(in_pie_s), .in_pp_s(in_pp_s), .in_ie_m(in_ie_m),
        .in_pie_m(in_pie_m), .in_pp_m(in_pp_m), .in_pv_m(in_pv_m),
        .in_mprv(in_mprv), .in_trap_sret(in_trap_sret), .in_pv_s(in_pv_s),
        .in_vtrap_sret(in_vtrap_sret), .sepc_i(sepc_i), .mepc_i(mepc_i),
        .cfg_c(cfg_c), .cfg_u(cfg_u), .cfg_h(cfg_h), .cfg_pmp(cfg_pmp),
        .cfg_v112(cfg_v112), .cfg_pmp_rules(cfg_pmp_rules),
        .done_o(done_o), .exc_o(exc_o), .exc_code_o(exc_code_o),
        .out_ie_s(out_ie_s), .out_pie_s(out_pie_s), .out_pp_s(out_pp_s),
        .out_ie_m(out_ie_m), .out_pie_m(out_pie_m), .out_pp_m(out_pp_m),
        .out_pv_m(out_pv_m), .out_mprv(out_mprv), .out_pv_s(out_pv_s),
        .new_priv_o(new_priv_o), .new_virt_o(new_virt_o),
        .ret_pc_o(ret_pc_o), .bank_swap_o(bank_swap_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        req_valid = 0; req_mret = 0; cur_priv = 2'd3; cur_virt = 0;
        in_ie_s = 0; in_pie_s = 0; in_pp_s = 0; in_ie_m = 0; in_pie_m = 0;
        in_pp_m = 2'd0; in_pv_m = 0; in_mprv = 0; in_trap_sret = 0;
        in_pv_s = 0; in_vtrap_sret = 0; sepc_i = 32'h100; mepc_i = 32'h200;
        cfg_c = 1; cfg_u = 1; cfg_h = 0; cfg_pmp = 0; cfg_v112 = 1; cfg_pmp_rules = 1;
    endtask

    task automatic fire();
        @(negedge clk); req_valid = 1;
        @(negedge clk); req_valid = 0;
    endtask

    task automatic expect_exc(input string tag, input logic [4:0] code);
        chk({tag, " exc"}, exc_o, 1);
        chk({tag, " code"}, exc_code_o, code);
    endtask

    task automatic t_reset();
        chk("R12 done after reset", done_o, 0);
        chk("R12 exc after reset", exc_o, 0);
    endtask

    task automatic t_priv();
        defaults(); cur_priv = 2'd0; fire(); expect_exc("R1 sret from U", 2);
        defaults(); req_mret = 1; cur_priv = 2'd1; fire(); expect_exc("R1 mret from S", 2);
        defaults(); cur_priv = 2'd1; in_pp_s = 1; in_pie_s = 1; in_ie_s = 0; in_pv_s = 1;
        fire();
        chk("R11 exc-free baseline", exc_o, 0);
        defaults(); cur_priv = 2'd0; cur_virt = 1; in_pie_s = 1; in_pp_s = 1; in_mprv = 1;
        fire();
        chk("R11 ie_s kept", out_ie_s, 0);
        chk("R11 pie_s kept", out_pie_s, 1);
        chk("R11 pp_s kept", out_pp_s, 1);
        chk("R11 mprv kept", out_mprv, 1);
        chk("R11 priv kept", new_priv_o, 0);
        chk("R11 virt kept", new_virt_o, 1);
        chk("R11 no swap", bank_swap_o, 0);
    endtask

    task automatic t_align();
        defaults(); cfg_c = 0; cur_priv = 2'd1; sepc_i = 32'h102; fire();
        expect_exc("R2 sret misaligned", 0);
        defaults(); cfg_c = 1; cur_priv = 2'd1; sepc_i = 32'h102; fire();
        chk("R2 compressed accepts", exc_o, 0);
        chk("R2 pc", ret_pc_o, 32'h102);
        defaults(); cfg_c = 0; req_mret = 1; mepc_i = 32'h201; in_pp_m = 2'd3; fire();
        expect_exc("R2 mret misaligned", 0);
    endtask

    task automatic t_tsr();
        defaults(); cur_priv = 2'd1; in_trap_sret = 1; fire(); expect_exc("R3 trap sret S", 2);
        defaults(); cur_priv = 2'd3; in_trap_sret = 1; fire(); chk("R3 trap sret M ok", exc_o, 0);
        defaults(); cur_priv = 2'd1; cur_virt = 1; in_vtrap_sret = 1; fire();
        expect_exc("R3 virtual trap", 22);
    endtask

    task automatic t_sret_pop();
        defaults(); cur_priv = 2'd1; in_pie_s = 1; in_ie_s = 0; in_pp_s = 1; fire();
        chk("R4 ok", exc_o, 0);
        chk("R4 ie_s", out_ie_s, 1);
        chk("R4 pie_s", out_pie_s, 1);
        chk("R4 pp_s", out_pp_s, 0);
        chk("R4 priv S", new_priv_o, 1);
        chk("R4 pc", ret_pc_o, 32'h100);
        defaults(); cur_priv = 2'd3; in_pie_s = 0; in_ie_s = 1; in_pp_s = 0; fire();
        chk("R4 ie_s cleared", out_ie_s, 0);
        chk("R4 priv U", new_priv_o, 0);
    endtask

    task automatic t_mprv();
        defaults(); in_mprv = 1; fire(); chk("R5 sret v112 clears", out_mprv, 0);
        defaults(); in_mprv = 1; cfg_v112 = 0; fire(); chk("R5 sret old keeps", out_mprv, 1);
        defaults(); req_mret = 1; in_mprv = 1; in_pp_m = 2'd3; fire();
        chk("R5 mret to M keeps", out_mprv, 1);
        defaults(); req_mret = 1; in_mprv = 1; in_pp_m = 2'd1; fire();
        chk("R5 mret to S clears", out_mprv, 0);
        defaults(); req_mret = 1; in_mprv = 1; in_pp_m = 2'd1; cfg_v112 = 0; fire();
        chk("R5 mret old keeps", out_mprv, 1);
    endtask

    task automatic t_sret_virt();
        defaults(); cfg_h = 1; cur_priv = 2'd1; in_pv_s = 1; in_pp_s = 1; fire();
        chk("R6 virt restored", new_virt_o, 1);
        chk("R6 pv_s cleared", out_pv_s, 0);
        chk("R6 swap", bank_swap_o, 1);
        defaults(); cfg_h = 1; cur_priv = 2'd1; cur_virt = 1; in_pv_s = 1; fire();
        chk("R6 virt on keeps pv_s", out_pv_s, 1);
        chk("R6 virt on keeps virt", new_virt_o, 1);
        chk("R6 virt on no swap", bank_swap_o, 0);
        defaults(); cfg_h = 0; cur_priv = 2'd1; in_pv_s = 1; fire();
        chk("R6 no H keeps virt", new_virt_o, 0);
        chk("R6 no H keeps pv_s", out_pv_s, 1);
    endtask

    task automatic t_mret_pop();
        defaults(); req_mret = 1; in_pie_m = 1; in_ie_m = 0; in_pp_m = 2'd1; in_pv_m = 1; fire();
        chk("R7 ok", exc_o, 0);
        chk("R7 ie_m", out_ie_m, 1);
        chk("R7 pie_m", out_pie_m, 1);
        chk("R7 pp_m user", out_pp_m, 0);
        chk("R7 pv_m cleared", out_pv_m, 0);
        chk("R7 priv S", new_priv_o, 1);
        chk("R7 pc", ret_pc_o, 32'h200);
        defaults(); req_mret = 1; cfg_u = 0; in_pp_m = 2'd3; fire();
        chk("R7 pp_m machine", out_pp_m, 3);
        chk("R7 priv M", new_priv_o, 3);
    endtask

    task automatic t_mret_virt();
        defaults(); req_mret = 1; cfg_h = 1; in_pv_m = 1; in_pp_m = 2'd1; fire();
        chk("R8 virt set", new_virt_o, 1);
        chk("R8 swap", bank_swap_o, 1);
        defaults(); req_mret = 1; cfg_h = 1; in_pv_m = 1; in_pp_m = 2'd3; fire();
        chk("R8 to M no virt", new_virt_o, 0);
        chk("R8 to M no swap", bank_swap_o, 0);
        defaults(); req_mret = 1; cfg_h = 0; in_pv_m = 1; in_pp_m = 2'd1; cur_virt = 0; fire();
        chk("R8 no H keeps virt", new_virt_o, 0);
        chk("R8 no H no swap", bank_swap_o, 0);
    endtask

    task automatic t_pmp();
        defaults(); req_mret = 1; cfg_pmp = 1; cfg_pmp_rules = 0; in_pp_m = 2'd0; fire();
        expect_exc("R9 no rules", 1);
        defaults(); req_mret = 1; cfg_pmp = 1; cfg_pmp_rules = 0; in_pp_m = 2'd3; fire();
        chk("R9 to M ok", exc_o, 0);
        defaults(); req_mret = 1; cfg_pmp = 1; cfg_pmp_rules = 1; in_pp_m = 2'd0; fire();
        chk("R9 rules ok", exc_o, 0);
    endtask

    task automatic t_order();
        defaults(); req_mret = 1; cur_priv = 2'd1; cfg_c = 0; mepc_i = 32'h202;
        cfg_pmp = 1; cfg_pmp_rules = 0; fire();
        expect_exc("R10 priv before align", 2);
        defaults(); req_mret = 1; cfg_c = 0; mepc_i = 32'h202; cfg_pmp = 1; cfg_pmp_rules = 0; fire();
        expect_exc("R10 align before pmp", 0);
        defaults(); cur_priv = 2'd1; cfg_c = 0; sepc_i = 32'h101; in_trap_sret = 1; fire();
        expect_exc("R10 align before trap", 0);
        defaults(); cur_priv = 2'd1; cur_virt = 1; in_trap_sret = 1; in_vtrap_sret = 1; fire();
        expect_exc("R10 trap before virtual", 2);
    endtask

    task automatic t_idle();
        defaults(); fire();
        chk("R12 done after req", done_o, 1);
        @(negedge clk);
        chk("R12 done falls", done_o, 0);
    endtask

    initial begin
        defaults();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_priv();
        t_align();
        t_tsr();
        t_sret_pop();
        t_mprv();
        t_sret_virt();
        t_mret_pop();
        t_mret_virt();
        t_pmp();
        t_order();
        t_idle();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule